// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and watches each port's enable and address. When both ports are enabled on the same address, it marks exactly one of them busy (active-low) and suppresses that port's write strobe until the collision ends. The port that reached the shared address later loses. Arrival order is judged at clock edges. A port whose enable and address were already present on the previous edge counts as earlier. If both ports begin colliding on the same edge, the left port keeps access.

The block has two modes, picked by `master_mode_i`. In master mode it drives both busy outputs from its own decision. In slave mode both busy outputs rest high, and the external busy inputs, driven by a master elsewhere, gate the write strobes. The gated write enables `l_we_o` and `r_we_o` are the strobes the memory array is meant to use.

Top module: `dp_collision_arb`

## Requirements
- R1: In master mode, both `l_busy_no` and `r_busy_no` are high whenever either port's enable is low or the two addresses differ.
- R2: In master mode, when both enables are high and the addresses are equal, exactly one of `l_busy_no` / `r_busy_no` is low, in that same cycle.
- R3: When a collision begins, the busy port is the one that was not already enabled at the same address on the previous clock edge. If left was already there and right just arrived, `r_busy_no` goes low. In the mirror case, `l_busy_no` goes low.
- R4: When neither port was already enabled at the shared address on the previous edge, the right port is flagged busy and the left port keeps access.
- R5: For as long as the collision persists, the busy port stays busy. The other port is never pre-empted, whatever the write strobes do.
- R6: `l_busy_no` and `r_busy_no` are never low together. Both return high in the same cycle that the match ends.
- R7: `l_we_o` equals `l_en_i & l_we_i`, and `r_we_o` equals `r_en_i & r_we_i`, except that a port's write enable is forced low while that port is blocked.
- R8: In master mode, a port is blocked when this block flags it busy, and the external busy inputs have no effect on any output. In slave mode, both busy outputs are high, and a port is blocked exactly when its external busy input (`l_busy_ni` / `r_busy_ni`) is low.
- R9: Addresses are `ADDR_W` bits wide, 15 by default, covering 32768 locations. All bits take part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_mode_i | input | 1 | 1: drive busy outputs; 0: take busy from inputs |
| l_en_i | input | 1 | Left port enable, active high |
| l_addr_i | input | ADDR_W | Left port address |
| l_we_i | input | 1 | Left port write request |
| l_busy_ni | input | 1 | Left external busy (slave mode), active low |
| r_en_i | input | 1 | Right port enable, active high |
| r_addr_i | input | ADDR_W | Right port address |
| r_we_i | input | 1 | Right port write request |
| r_busy_ni | input | 1 | Right external busy (slave mode), active low |
| l_busy_no | output | 1 | Left busy, active low |
| r_busy_no | output | 1 | Right busy, active low |
| l_we_o | output | 1 | Gated left write enable |
| r_we_o | output | 1 | Gated right write enable |

## Verification
Two functions can fall in the same cycle. A port can gain access to an address in the same cycle that its partner makes a write request, and both ports can start a collision on one edge, which makes the tie-break and write suppression act together. The bench provokes both cases in directed form: staggered arrivals in either order, and simultaneous arrivals with writes already asserted. It also provokes them in random form, drawing addresses from a two-value pool so that collisions start, persist and end often. A bench model of arrival history predicts both busy outputs and both gated write enables every cycle. Each prediction is compared with the outputs between clock edges.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  typedef enum logic [1:0] {
    BLK_NONE  = 2'd0,
    BLK_LEFT  = 2'd1,
    BLK_RIGHT = 2'd2
  } blk_e;

  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
  localparam int unsigned N_PORTS = 2;
endpackage

// File: rtl/dp_req_track.sv
module dp_req_track #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              held_o
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
    end
  end

  // request already present on the previous edge
  assign held_o = en_q & en_i & (addr_q == addr_i);
endmodule

// File: rtl/dp_blk_fsm.sv
module dp_blk_fsm
  import dp_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_en_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_held_i,
  input  logic              r_en_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_held_i,
  output blk_e              blk_o
);
  logic match;
  blk_e blk_q, blk_d;

  assign match = l_en_i & r_en_i & (l_addr_i == r_addr_i);

  always_comb begin
    if (!match)                   blk_d = BLK_NONE;
    else if (blk_q != BLK_NONE)   blk_d = blk_q;      // no pre-emption
    else if (r_held_i && !l_held_i) blk_d = BLK_LEFT;
    else                          blk_d = BLK_RIGHT;  // left wins ties
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blk_q <= BLK_NONE;
    else         blk_q <= blk_d;
  end

  assign blk_o = blk_d;

  // R6
  blk_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q != 2'd3);
endmodule

// File: rtl/dp_wr_gate.sv
module dp_wr_gate (
  input  logic master_i,
  input  logic blk_own_i,
  input  logic busy_ext_ni,
  input  logic en_i,
  input  logic we_i,
  output logic busy_no,
  output logic we_o
);
  logic block;

  assign block   = master_i ? blk_own_i : ~busy_ext_ni;
  assign busy_no = master_i ? ~blk_own_i : 1'b1;
  assign we_o    = en_i & we_i & ~block;
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import dp_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_mode_i,
  input  logic              l_en_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_i,
  input  logic              l_busy_ni,
  input  logic              r_en_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_we_o,
  output logic              r_we_o
);
  logic [N_PORTS-1:0]             en, we, busy_ext_n, held, blk_own, busy_n, we_g;
  logic [N_PORTS-1:0][ADDR_W-1:0] addr;
  blk_e                           blk;

  assign en         = {r_en_i, l_en_i};
  assign we         = {r_we_i, l_we_i};
  assign busy_ext_n = {r_busy_ni, l_busy_ni};
  assign addr       = {r_addr_i, l_addr_i};
  assign blk_own    = {blk == BLK_RIGHT, blk == BLK_LEFT};

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    dp_req_track #(.ADDR_W(ADDR_W)) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[p]),
      .addr_i (addr[p]),
      .held_o (held[p])
    );
    dp_wr_gate u_gate (
      .master_i    (master_mode_i),
      .blk_own_i   (blk_own[p]),
      .busy_ext_ni (busy_ext_n[p]),
      .en_i        (en[p]),
      .we_i        (we[p]),
      .busy_no     (busy_n[p]),
      .we_o        (we_g[p])
    );
  end

  dp_blk_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .l_en_i   (l_en_i),
    .l_addr_i (l_addr_i),
    .l_held_i (held[PORT_L]),
    .r_en_i   (r_en_i),
    .r_addr_i (r_addr_i),
    .r_held_i (held[PORT_R]),
    .blk_o    (blk)
  );

  assign l_busy_no = busy_n[PORT_L];
  assign r_busy_no = busy_n[PORT_R];
  assign l_we_o    = we_g[PORT_L];
  assign r_we_o    = we_g[PORT_R];

  logic hit;
  assign hit = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  // R1
  no_hit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (l_busy_no && r_busy_no));
  // R2
  one_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_mode_i && hit) |-> (l_busy_no != r_busy_no));
  // R6
  busy_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_no || r_busy_no));
  // R5
  hold_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_mode_i && $past(master_mode_i) && hit && $past(hit) && !$past(l_busy_no))
      |-> !l_busy_no);
  // R5
  hold_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_mode_i && $past(master_mode_i) && hit && $past(hit) && !$past(r_busy_no))
      |-> !r_busy_no);
  // R7
  blocked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_mode_i && !r_busy_no) |-> !r_we_o);
  // R8
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_mode_i |-> (l_busy_no && r_busy_no));
endmodule

// File: tb/dp_collision_arb_bench.sv
`timescale 1ns/1ps
module dp_collision_arb_bench;
  localparam int unsigned ADDR_W = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master, l_en, l_we, l_bi, r_en, r_we, r_bi;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic l_busy_no, r_busy_no, l_we_o, r_we_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state
  logic             m_lpe, m_rpe;
  logic [ADDR_W-1:0] m_lpa, m_rpa;
  int               m_own;  // 0 none, 1 left blocked, 2 right blocked
  int               m_blk;

  always #2.5 clk = ~clk;

  dp_collision_arb #(.ADDR_W(ADDR_W)) u_dp_collision_arb (
    .clk_i(clk), .rst_ni(rst_ni), .master_mode_i(master),
    .l_en_i(l_en), .l_addr_i(l_addr), .l_we_i(l_we), .l_busy_ni(l_bi),
    .r_en_i(r_en), .r_addr_i(r_addr), .r_we_i(r_we), .r_busy_ni(r_bi),
    .l_busy_no(l_busy_no), .r_busy_no(r_busy_no), .l_we_o(l_we_o), .r_we_o(r_we_o)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pred_blk();
    logic hit, lh, rh;
    hit = l_en && r_en && (l_addr == r_addr);
    lh  = m_lpe && l_en && (m_lpa == l_addr);
    rh  = m_rpe && r_en && (m_rpa == r_addr);
    if (!hit) return 0;
    if (m_own != 0) return m_own;
    if (rh && !lh) return 1;
    return 2;
  endfunction

  task automatic apply(string tag, logic md, logic le, logic [ADDR_W-1:0] la, logic lw, logic lb,
                       logic re, logic [ADDR_W-1:0] ra, logic rw, logic rb);
    logic lblk, rblk;
    @(negedge clk);
    master = md; l_en = le; l_addr = la; l_we = lw; l_bi = lb;
    r_en = re; r_addr = ra; r_we = rw; r_bi = rb;
    #1;
    m_blk = pred_blk();
    lblk = md ? (m_blk == 1) : !lb;
    rblk = md ? (m_blk == 2) : !rb;
    chk(tag, "l_busy_no", l_busy_no, md ? !(m_blk == 1) : 1'b1);
    chk(tag, "r_busy_no", r_busy_no, md ? !(m_blk == 2) : 1'b1);
    chk(tag, "l_we_o", l_we_o, le && lw && !lblk);
    chk(tag, "r_we_o", r_we_o, re && rw && !rblk);
    chk("R6", "busy mutex", l_busy_no || r_busy_no, 1'b1);
  endtask

  task automatic tick();
    @(posedge clk);
    m_lpe = l_en; m_lpa = l_addr; m_rpe = r_en; m_rpa = r_addr;
    m_own = m_blk;
  endtask

  task automatic idle();
    apply("R1", 1, 0, 0, 0, 1, 0, 0, 0, 1);
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_lpe = 0; m_rpe = 0; m_lpa = '0; m_rpa = '0; m_own = 0; m_blk = 0;
    master = 1; l_en = 0; l_addr = '0; l_we = 0; l_bi = 1;
    r_en = 0; r_addr = '0; r_we = 0; r_bi = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset l_busy_no", l_busy_no, 1'b1);
    chk("R1", "reset r_busy_no", r_busy_no, 1'b1);
    chk("R7", "reset l_we_o", l_we_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    tick();

    // R1: different addresses, one bit apart at the top
    apply("R1", 1, 1, 15'h4000, 1, 1, 1, 15'h0000, 1, 1);
    chk("R9", "msb mismatch l_we_o", l_we_o, 1'b1);
    tick();
    idle();

    // R3: left first, right arrives later with write
    apply("R3", 1, 1, 15'h0123, 0, 1, 0, 0, 0, 1); tick();
    apply("R3", 1, 1, 15'h0123, 1, 1, 1, 15'h0123, 1, 1);
    chk("R3", "late right busy", r_busy_no, 1'b0);
    chk("R7", "right write blocked", r_we_o, 1'b0);
    chk("R7", "left write passes", l_we_o, 1'b1);
    tick();
    // R5: persist, toggle writes
    for (int i = 0; i < 4; i++) begin
      apply("R5", 1, 1, 15'h0123, i[0], 1, 1, 15'h0123, ~i[0], 1);
      chk("R5", "right stays busy", r_busy_no, 1'b0);
      tick();
    end
    // R6: left leaves, busy released same cycle
    apply("R6", 1, 0, 15'h0123, 0, 1, 1, 15'h0123, 1, 1);
    chk("R6", "release r_busy_no", r_busy_no, 1'b1);
    chk("R6", "release r_we_o", r_we_o, 1'b1);
    tick();
    idle();

    // R3: right first, left arrives later
    apply("R3", 1, 0, 0, 0, 1, 1, 15'h7FFF, 1, 1); tick();
    apply("R3", 1, 1, 15'h7FFF, 1, 1, 1, 15'h7FFF, 1, 1);
    chk("R3", "late left busy", l_busy_no, 1'b0);
    chk("R7", "left write blocked", l_we_o, 1'b0);
    tick();
    idle();

    // R4: simultaneous arrival
    apply("R4", 1, 1, 15'h2AAA, 1, 1, 1, 15'h2AAA, 1, 1);
    chk("R4", "tie right busy", r_busy_no, 1'b0);
    chk("R4", "tie left free", l_busy_no, 1'b1);
    tick();
    // R4: both move to a new shared address together
    apply("R4", 1, 1, 15'h1555, 1, 1, 1, 15'h1555, 1, 1);
    chk("R4", "move right busy", r_busy_no, 1'b0);
    tick();
    idle();

    // R8: master ignores external busy
    apply("R8", 1, 1, 15'h0010, 1, 0, 1, 15'h0020, 1, 0);
    chk("R8", "master ignores l_busy_ni", l_we_o, 1'b1);
    chk("R8", "master ignores r_busy_ni", r_we_o, 1'b1);
    tick();
    // R8: slave mode, colliding, busy outs quiet, external busy gates
    apply("R8", 0, 1, 15'h0033, 1, 1, 1, 15'h0033, 1, 0);
    chk("R8", "slave l_busy_no", l_busy_no, 1'b1);
    chk("R8", "slave r_busy_no", r_busy_no, 1'b1);
    chk("R8", "slave right blocked", r_we_o, 1'b0);
    chk("R8", "slave left passes", l_we_o, 1'b1);
    tick();
    idle();

    // random phase: R2 R3 R4 R5 R6 R7 R8 via model
    for (int n = 0; n < 3000; n++) begin
      logic md, le, re;
      logic [ADDR_W-1:0] la, ra;
      md = ($urandom_range(9) != 0);
      le = ($urandom_range(3) != 0);
      re = ($urandom_range(3) != 0);
      la = ($urandom_range(7) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(1) + 3);
      ra = ($urandom_range(7) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(1) + 3);
      apply("R2", md, le, la, 1'($urandom), 1'($urandom), re, ra, 1'($urandom), 1'($urandom));
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule